// File: doc/BRIEF.md
# Serial Flash Geometry Probe

This block finds out, after a start pulse, what kind of buffer-paged serial flash sits on its SPI pins and reports that part's geometry: how many pages it has, how many bytes each page holds, the bit position at which the page number starts within a device address, and the total capacity in bytes. It drives the SPI bus itself as a mode-0 master, one byte at a time, with chip select framing each command.

Identification runs in two stages. The block first asks for the identity bytes and looks at the first three. When the manufacturer byte is the expected one, the device code selects a density class. For classes that can run with power-of-two pages, a second command reads the status byte, and its lowest bit chooses between the binary page size and the larger non-binary one. When the manufacturer byte is anything else, the block falls back to an older scheme: it reads the status byte and decodes a density field held in its middle bits. A part it cannot place, or a status byte that shows no device at all, ends the probe with an error instead of a geometry.

The results stay on the outputs from the end of one probe until the next accepted start. A host sequencer, or the boot logic of the chip, pulses start once after reset, waits for busy to fall, and then reads the geometry or the error flag.

Top module: `flash_geom_probe`

## Requirements
- R1: An accepted start pulls chip select low and sends opcode 0x9F, most significant bit first, in SPI mode 0 (clock idles low, the device samples on the rising edge). It then clocks in three identity bytes, namely manufacturer, device code and extension, and raises chip select again.
- R2: If the manufacturer is 0x1F and the extension is 0x00, the device code picks a class with power-of-two page support: 0x22 gives 512 pages, 0x23 gives 1024, 0x24 gives 2048 and 0x25 gives 4096, all with binary shift 8. 0x26 gives 4096 pages with binary shift 9, and 0x28 gives 8192 pages with binary shift 10. Code 0x27 with extension 0x01 gives 8192 pages with binary shift 9. For these classes the block then reads the status byte with opcode 0xD7 in a second chip-select frame. If status bit 0 is 1, the page size is 2^s and the shift is s, where s is the binary shift. If status bit 0 is 0, the page size is 2^s + 2^(s-5) and the shift is s+1.
- R3: Manufacturer 0x1F with device code 0x27 and extension 0x00 gives 8192 pages of 528 bytes with shift 10, regardless of status, and no status command is sent.
- R4: Manufacturer 0x1F with any identity not listed in R2 or R3 ends the probe with the error flag set, and no status command is sent.
- R5: A manufacturer byte other than 0x1F leads to a status read with opcode 0xD7. A status byte of 0x00 or 0xFF ends the probe with the error flag set.
- R6: In the fallback path, status bits 5:2 (status AND 0x3C) select the geometry, and bit 0 has no effect. 0x0C gives 512x264, 0x14 gives 1024x264, 0x1C gives 2048x264 and 0x24 gives 4096x264, all with shift 9. 0x2C gives 4096x528 and 0x34 gives 8192x528, both with shift 10. 0x38 and 0x3C give 8192x1056 with shift 11.
- R7: In the fallback path, any other value of status AND 0x3C ends the probe with the error flag set.
- R8: When the probe succeeds, the capacity output equals page count times page size. When it fails, page count, page size, shift and capacity are all 0.
- R9: Busy is high from the cycle after an accepted start until the results appear. Valid and error are never high together. A start that arrives while busy is high is ignored. When no start arrives, all results hold their values.
- R10: While idle, chip select is high. Whenever chip select is high, the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to run a probe |
| busy | output | 1 | A probe is in progress |
| spi_sclk | output | 1 | Serial clock to the flash |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| geo_valid | output | 1 | Geometry outputs hold a recognised part |
| geo_error | output | 1 | The last probe found no part or an unknown one |
| page_count | output | 16 | Number of pages |
| page_size | output | 12 | Bytes per page |
| page_shift | output | 4 | Bit position of the page number in a device address |
| capacity | output | 28 | Total bytes, page count times page size |

## Verification
The bench builds the probe with the serial clock half-period set to 2 system clocks. At that setting a full byte takes 32 cycles, so a complete two-frame probe fits in a few hundred cycles, and the bench can cover every device code, both settings of status bit 0, and the fallback and error classes. It can also land a second start in the middle of a frame. A behavioural flash on the SPI pins answers each opcode and logs the opcodes it receives. This shows whether the status frame was sent or correctly left out, which the geometry outputs alone cannot show.

// File: rtl/fgp_pkg.sv
// Shared widths, opcodes and the geometry record for the flash geometry probe.
// Assumes page sizes up to 2^11 bytes and page counts up to 2^15.
package fgp_pkg;
    localparam int PAGES_W = 16;
    localparam int SIZE_W  = 12;
    localparam int SHIFT_W = 4;
    localparam int LOG_W   = 4;
    localparam int CAP_W   = PAGES_W + SIZE_W;

    localparam logic [7:0] OPC_IDENT  = 8'h9F;
    localparam logic [7:0] OPC_STATUS = 8'hD7;
    localparam logic [7:0] MFR_CODE   = 8'h1F;

    typedef struct packed {
        logic [PAGES_W-1:0] pages;
        logic [SIZE_W-1:0]  size;
        logic [SHIFT_W-1:0] shift;
    } geom_t;

    // Build a geometry from log2(pages), the binary shift and the page mode.
    // Non-binary pages are 2^s + 2^(s-5) bytes and use one more address bit.
    function automatic geom_t make_geom(input logic [LOG_W-1:0] pages_log2,
                                        input logic [SHIFT_W-1:0] bin_shift,
                                        input logic binary);
        geom_t g;
        g.pages = PAGES_W'(1) << pages_log2;
        if (binary) begin
            g.size  = SIZE_W'(1) << bin_shift;
            g.shift = bin_shift;
        end else begin
            g.size  = (SIZE_W'(1) << bin_shift) + (SIZE_W'(1) << (bin_shift - SHIFT_W'(5)));
            g.shift = bin_shift + SHIFT_W'(1);
        end
        return g;
    endfunction
endpackage

// File: rtl/fgp_spi_byte.sv
// Mode-0 SPI master byte engine: shifts one byte out MSB first while shifting
// one byte in. Chip select is handled by the caller. Assumes go is only
// pulsed while the engine is idle. HALF_DIV is the serial clock half-period.
module fgp_spi_byte #(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    output logic [7:0] rx_byte,
    output logic       done,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    logic             active;
    logic [DIV_W-1:0] div_cnt;
    logic             sclk_q;
    logic [2:0]       bit_cnt;
    logic [7:0]       tx_sr;
    logic [7:0]       rx_sr;
    logic             done_q;

    // Clock divider, edge generation and both shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            div_cnt <= '0;
            sclk_q  <= 1'b0;
            bit_cnt <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active) begin
                if (go) begin
                    active  <= 1'b1;
                    tx_sr   <= tx_byte;
                    div_cnt <= '0;
                    bit_cnt <= '0;
                    sclk_q  <= 1'b0;
                end
            end else if (div_cnt == DIV_LAST) begin
                div_cnt <= '0;
                sclk_q  <= ~sclk_q;
                if (!sclk_q) begin
                    rx_sr <= {rx_sr[6:0], miso};
                end else if (bit_cnt == 3'd7) begin
                    active <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 3'd1;
                    tx_sr   <= {tx_sr[6:0], 1'b0};
                end
            end else begin
                div_cnt <= div_cnt + DIV_W'(1);
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = tx_sr[7];
    assign rx_byte = rx_sr;
    assign done    = done_q;
endmodule

// File: rtl/fgp_ident_decode.sv
// Maps the three identity bytes to a geometry. Reports whether the
// manufacturer matched, whether the identity is known, and whether the page
// mode must be read from status. Assumes stat_bin is only meaningful when
// needs_status is high.
module fgp_ident_decode
    import fgp_pkg::*;
(
    input  logic [7:0] mfr,
    input  logic [7:0] dev,
    input  logic [7:0] ext,
    input  logic       stat_bin,
    output logic       mfr_ok,
    output logic       known,
    output logic       needs_status,
    output geom_t      geom
);
    logic [LOG_W-1:0]   plog;
    logic [SHIFT_W-1:0] bshift;

    // Density class lookup from device code and extension byte.
    always_comb begin
        known        = 1'b1;
        needs_status = 1'b1;
        plog         = LOG_W'(9);
        bshift       = SHIFT_W'(8);
        unique case (dev)
            8'h22: plog = LOG_W'(9);
            8'h23: plog = LOG_W'(10);
            8'h24: plog = LOG_W'(11);
            8'h25: plog = LOG_W'(12);
            8'h26: begin plog = LOG_W'(12); bshift = SHIFT_W'(9); end
            8'h27: begin plog = LOG_W'(13); bshift = SHIFT_W'(9); end
            8'h28: begin plog = LOG_W'(13); bshift = SHIFT_W'(10); end
            default: known = 1'b0;
        endcase
        if (dev == 8'h27) begin
            if (ext == 8'h00)      needs_status = 1'b0;
            else if (ext != 8'h01) known = 1'b0;
        end else if (ext != 8'h00) begin
            known = 1'b0;
        end
    end

    assign mfr_ok = (mfr == MFR_CODE);
    assign geom   = make_geom(plog, bshift, needs_status & stat_bin);
endmodule

// File: rtl/fgp_legacy_decode.sv
// Fallback decode of the density field in the status byte (bits 5:2).
// Flags an all-zero or all-one status as an absent device.
module fgp_legacy_decode
    import fgp_pkg::*;
(
    input  logic [7:0] status,
    output logic       absent,
    output logic       known,
    output geom_t      geom
);
    logic [LOG_W-1:0]   plog;
    logic [SHIFT_W-1:0] bshift;

    // Density field lookup; every fallback part uses non-binary pages.
    always_comb begin
        known  = 1'b1;
        plog   = LOG_W'(9);
        bshift = SHIFT_W'(8);
        unique case (status[5:2])
            4'b0011: plog = LOG_W'(9);
            4'b0101: plog = LOG_W'(10);
            4'b0111: plog = LOG_W'(11);
            4'b1001: plog = LOG_W'(12);
            4'b1011: begin plog = LOG_W'(12); bshift = SHIFT_W'(9); end
            4'b1101: begin plog = LOG_W'(13); bshift = SHIFT_W'(9); end
            4'b1110,
            4'b1111: begin plog = LOG_W'(13); bshift = SHIFT_W'(10); end
            default: known = 1'b0;
        endcase
    end

    assign absent = (status == 8'h00) || (status == 8'hFF);
    assign geom   = make_geom(plog, bshift, 1'b0);
endmodule

// File: rtl/flash_geom_probe.sv
// Start-up probe for a buffer-paged serial flash. Runs the identity frame,
// optionally a status frame, and registers the resulting geometry or an
// error. Assumes a single attached device and mode-0 SPI timing.
module flash_geom_probe
    import fgp_pkg::*;
#(
    parameter int SCLK_HALF = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               busy,
    output logic               spi_sclk,
    output logic               spi_cs_n,
    output logic               spi_mosi,
    input  logic               spi_miso,
    output logic               geo_valid,
    output logic               geo_error,
    output logic [PAGES_W-1:0] page_count,
    output logic [SIZE_W-1:0]  page_size,
    output logic [SHIFT_W-1:0] page_shift,
    output logic [CAP_W-1:0]   capacity
);
    typedef enum logic [3:0] {
        S_IDLE, S_ID_OP, S_ID_B0, S_ID_B1, S_ID_B2,
        S_DECIDE, S_ST_OP, S_ST_B, S_FINAL
    } state_t;

    state_t     state;
    logic       cs_q;
    logic       go_q;
    logic [7:0] tx_q;
    logic [7:0] id_mfr, id_dev, id_ext, stat_q;
    logic       legacy_q;

    logic [7:0] rx_byte;
    logic       xfer_done;

    logic  id_mfr_ok, id_known, id_needs_st;
    geom_t id_geom;
    logic  lg_absent, lg_known;
    geom_t lg_geom;

    logic  fin_ok;
    geom_t fin_geom;

    fgp_spi_byte #(.HALF_DIV(SCLK_HALF)) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go_q),
        .tx_byte (tx_q),
        .rx_byte (rx_byte),
        .done    (xfer_done),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .miso    (spi_miso)
    );

    fgp_ident_decode i_ident (
        .mfr          (id_mfr),
        .dev          (id_dev),
        .ext          (id_ext),
        .stat_bin     (stat_q[0]),
        .mfr_ok       (id_mfr_ok),
        .known        (id_known),
        .needs_status (id_needs_st),
        .geom         (id_geom)
    );

    fgp_legacy_decode i_legacy (
        .status (stat_q),
        .absent (lg_absent),
        .known  (lg_known),
        .geom   (lg_geom)
    );

    // Choose the decoder that applies to the path taken.
    always_comb begin
        if (legacy_q) begin
            fin_ok   = !lg_absent && lg_known;
            fin_geom = lg_geom;
        end else begin
            fin_ok   = id_mfr_ok && id_known;
            fin_geom = id_geom;
        end
    end

    // Probe sequencer: frames, byte launches and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            cs_q       <= 1'b1;
            go_q       <= 1'b0;
            tx_q       <= '0;
            id_mfr     <= '0;
            id_dev     <= '0;
            id_ext     <= '0;
            stat_q     <= '0;
            legacy_q   <= 1'b0;
            geo_valid  <= 1'b0;
            geo_error  <= 1'b0;
            page_count <= '0;
            page_size  <= '0;
            page_shift <= '0;
            capacity   <= '0;
        end else begin
            go_q <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    cs_q      <= 1'b0;
                    go_q      <= 1'b1;
                    tx_q      <= OPC_IDENT;
                    stat_q    <= '0;
                    legacy_q  <= 1'b0;
                    geo_valid <= 1'b0;
                    geo_error <= 1'b0;
                    state     <= S_ID_OP;
                end
                S_ID_OP: if (xfer_done) begin
                    go_q  <= 1'b1;
                    tx_q  <= 8'h00;
                    state <= S_ID_B0;
                end
                S_ID_B0: if (xfer_done) begin
                    id_mfr <= rx_byte;
                    go_q   <= 1'b1;
                    state  <= S_ID_B1;
                end
                S_ID_B1: if (xfer_done) begin
                    id_dev <= rx_byte;
                    go_q   <= 1'b1;
                    state  <= S_ID_B2;
                end
                S_ID_B2: if (xfer_done) begin
                    id_ext <= rx_byte;
                    cs_q   <= 1'b1;
                    state  <= S_DECIDE;
                end
                S_DECIDE: begin
                    if (id_mfr_ok && (!id_known || !id_needs_st)) begin
                        state <= S_FINAL;
                    end else begin
                        legacy_q <= !id_mfr_ok;
                        cs_q     <= 1'b0;
                        go_q     <= 1'b1;
                        tx_q     <= OPC_STATUS;
                        state    <= S_ST_OP;
                    end
                end
                S_ST_OP: if (xfer_done) begin
                    go_q  <= 1'b1;
                    tx_q  <= 8'h00;
                    state <= S_ST_B;
                end
                S_ST_B: if (xfer_done) begin
                    stat_q <= rx_byte;
                    cs_q   <= 1'b1;
                    state  <= S_FINAL;
                end
                S_FINAL: begin
                    geo_valid <= fin_ok;
                    geo_error <= !fin_ok;
                    if (fin_ok) begin
                        page_count <= fin_geom.pages;
                        page_size  <= fin_geom.size;
                        page_shift <= fin_geom.shift;
                        capacity   <= CAP_W'(fin_geom.pages) * CAP_W'(fin_geom.size);
                    end else begin
                        page_count <= '0;
                        page_size  <= '0;
                        page_shift <= '0;
                        capacity   <= '0;
                    end
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy     = (state != S_IDLE);
    assign spi_cs_n = cs_q;
endmodule

// File: rtl/fgp_checker.sv
// Property checker for flash_geom_probe, attached by bind below.
module fgp_checker
    import fgp_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               spi_sclk,
    input logic               spi_cs_n,
    input logic               geo_valid,
    input logic               geo_error,
    input logic [PAGES_W-1:0] page_count,
    input logic [SIZE_W-1:0]  page_size,
    input logic [SHIFT_W-1:0] page_shift
);
    // R10
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R10
    cs_high_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);

    // R9
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(geo_valid && geo_error));

    // R9
    results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(geo_valid) && $stable(geo_error) &&
            $stable(page_count) && $stable(page_size) && $stable(page_shift)));

    // R8
    error_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        geo_error |-> (page_count == '0 && page_size == '0 && page_shift == '0));

    // R2
    size_vs_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        geo_valid |-> ((32'(page_size) == (32'd1 << page_shift)) ||
            (32'(page_size) == ((32'd1 << page_shift) >> 1) + ((32'd1 << page_shift) >> 6))));
endmodule

bind flash_geom_probe fgp_checker i_fgp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .spi_sclk   (spi_sclk),
    .spi_cs_n   (spi_cs_n),
    .geo_valid  (geo_valid),
    .geo_error  (geo_error),
    .page_count (page_count),
    .page_size  (page_size),
    .page_shift (page_shift)
);

// File: tb/test_flash_geom_probe.sv
// Scoreboard bench: the driver queues the expected geometry for each probe,
// a monitor pops it when busy falls and compares. A behavioural flash model
// answers on the SPI pins and logs received opcodes.
module test_flash_geom_probe;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;

    typedef struct {
        bit      ok;
        int      pages;
        int      size;
        int      shift;
        string   req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, spi_sclk, spi_cs_n, spi_mosi, spi_miso;
    logic        geo_valid, geo_error;
    logic [15:0] page_count;
    logic [11:0] page_size;
    logic [3:0]  page_shift;
    logic [27:0] capacity;

    int checks = 0;
    int errors = 0;
    exp_t sb_q[$];

    // flash model state
    logic [7:0] m_id0, m_id1, m_id2, m_stat;
    int         m_nbits = 0;
    logic [7:0] m_in_sr = '0;
    logic [7:0] m_op = '0;
    logic [7:0] ops_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_geom_probe #(.SCLK_HALF(HALF)) i_flash_geom_probe (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .busy       (busy),
        .spi_sclk   (spi_sclk),
        .spi_cs_n   (spi_cs_n),
        .spi_mosi   (spi_mosi),
        .spi_miso   (spi_miso),
        .geo_valid  (geo_valid),
        .geo_error  (geo_error),
        .page_count (page_count),
        .page_size  (page_size),
        .page_shift (page_shift),
        .capacity   (capacity)
    );

    // Flash model: sample MOSI on rising SCLK, reset bit count on CS release.
    always @(posedge spi_sclk or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            m_nbits = 0;
        end else begin
            m_in_sr = {m_in_sr[6:0], spi_mosi};
            m_nbits = m_nbits + 1;
            if (m_nbits == 8) begin
                m_op = m_in_sr;
                ops_q.push_back(m_in_sr);
            end
        end
    end

    // Flash model: present the response bit for the current position.
    always @* begin
        logic [7:0] resp;
        int k;
        resp = 8'h00;
        k = (m_nbits / 8) - 1;
        if (m_op == 8'h9F)
            resp = (k == 0) ? m_id0 : (k == 1) ? m_id1 : (k == 2) ? m_id2 : 8'h00;
        else if (m_op == 8'hD7)
            resp = m_stat;
        if (spi_cs_n || m_nbits < 8) spi_miso = 1'b0;
        else spi_miso = resp[7 - (m_nbits % 8)];
    end

    task automatic chk(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: compare results against the scoreboard when a probe ends.
    always @(negedge clk) begin : monitor
        static logic busy_d = 1'b0;
        if (rst_n && busy_d && !busy) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected completion", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(geo_valid == e.ok, e.req, "valid", geo_valid, e.ok);
                chk(geo_error == !e.ok, e.req, "error", geo_error, !e.ok);
                chk(page_count == e.pages, e.req, "pages", page_count, e.pages);
                chk(page_size == e.size, e.req, "size", page_size, e.size);
                chk(page_shift == e.shift, e.req, "shift", page_shift, e.shift);
                chk(capacity == e.pages * e.size, "R8", "capacity", capacity, e.pages * e.size);
            end
        end
        busy_d = busy;
    end

    // Driver: set up the model, queue the expectation, run one probe.
    task automatic run_probe(input logic [7:0] id0, input logic [7:0] id1,
                             input logic [7:0] id2, input logic [7:0] st,
                             input bit ok, input int pages, input int size,
                             input int shift, input bit st_rd, input bit poke,
                             input string req);
        exp_t e;
        m_id0 = id0; m_id1 = id1; m_id2 = id2; m_stat = st;
        ops_q.delete();
        e.ok = ok; e.pages = ok ? pages : 0; e.size = ok ? size : 0;
        e.shift = ok ? shift : 0; e.req = req;
        sb_q.push_back(e);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R9", "busy after start", busy, 1);
        if (poke) begin
            repeat (40) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(ops_q.size() == (st_rd ? 2 : 1), "R1", "opcode frames", ops_q.size(), st_rd ? 2 : 1);
        if (ops_q.size() > 0) chk(ops_q[0] == 8'h9F, "R1", "identity opcode", ops_q[0], 8'h9F);
        if (st_rd && ops_q.size() > 1)
            chk(ops_q[1] == 8'hD7, "R2", "status opcode", ops_q[1], 8'hD7);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual 0 expected 1 (probe never finished)");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_id0 = 8'h00; m_id1 = 8'h00; m_id2 = 8'h00; m_stat = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state, R10 and R9
        chk(busy == 1'b0, "R9", "reset busy", busy, 0);
        chk(spi_cs_n == 1'b1, "R10", "reset cs_n", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R10", "reset sclk", spi_sclk, 0);
        chk(geo_valid == 1'b0 && geo_error == 1'b0, "R9", "reset flags",
            {geo_valid, geo_error}, 0);

        // R2: identity classes in both page modes
        run_probe(8'h1F, 8'h22, 8'h00, 8'h81, 1, 512, 256, 8, 1, 0, "R2");
        run_probe(8'h1F, 8'h22, 8'h00, 8'h80, 1, 512, 264, 9, 1, 0, "R2");
        run_probe(8'h1F, 8'h25, 8'h00, 8'h80, 1, 4096, 264, 9, 1, 0, "R2");
        run_probe(8'h1F, 8'h26, 8'h00, 8'h81, 1, 4096, 512, 9, 1, 0, "R2");
        run_probe(8'h1F, 8'h28, 8'h00, 8'h80, 1, 8192, 1056, 11, 1, 0, "R2");
        run_probe(8'h1F, 8'h27, 8'h01, 8'h81, 1, 8192, 512, 9, 1, 0, "R2");
        // R3: no power-of-two option, status ignored and not read
        run_probe(8'h1F, 8'h27, 8'h00, 8'h81, 1, 8192, 528, 10, 0, 0, "R3");
        // R4: unknown identities
        run_probe(8'h1F, 8'h29, 8'h00, 8'h81, 0, 0, 0, 0, 0, 0, "R4");
        run_probe(8'h1F, 8'h25, 8'h05, 8'h81, 0, 0, 0, 0, 0, 0, "R4");
        // R6: fallback density decode, bit 0 has no effect
        run_probe(8'h00, 8'h00, 8'h00, 8'h8D, 1, 512, 264, 9, 1, 0, "R6");
        run_probe(8'h00, 8'h00, 8'h00, 8'hAC, 1, 4096, 528, 10, 1, 0, "R6");
        run_probe(8'h00, 8'h00, 8'h00, 8'hB8, 1, 8192, 1056, 11, 1, 0, "R6");
        run_probe(8'h1E, 8'h22, 8'h00, 8'hBD, 1, 8192, 1056, 11, 1, 0, "R6");
        // R5: absent device
        run_probe(8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 1, 0, "R5");
        run_probe(8'hFF, 8'hFF, 8'hFF, 8'hFF, 0, 0, 0, 0, 1, 0, "R5");
        // R7: unsupported density field
        run_probe(8'h00, 8'h00, 8'h00, 8'h90, 0, 0, 0, 0, 1, 0, "R7");

        // R9: start while busy is ignored, then results hold
        run_probe(8'h1F, 8'h24, 8'h00, 8'h81, 1, 2048, 256, 8, 1, 1, "R9");
        repeat (100) @(negedge clk);
        chk(busy == 1'b0, "R9", "no restart", busy, 0);
        chk(page_count == 2048 && geo_valid, "R9", "held pages", page_count, 2048);
        chk(capacity == 2048 * 256, "R8", "held capacity", capacity, 2048 * 256);
        chk(sb_q.size() == 0, "R9", "pending results", sb_q.size(), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule